// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the address or operand value for one instruction step of a small 8-bit processor. The decoder gives it an addressing-mode code together with the current program counter, the six 16-bit register pairs, up to two operand bytes that follow the opcode, and a 3-bit restart index. It works out a 16-bit result. Depending on the mode, that result is a memory address, a new program counter value or a literal operand. It also says whether the result drives a memory access and whether it is immediate data.

The result is latched on the clock edge after a `start` pulse, and `valid` is high for that one cycle. While `start` is low the result registers keep their values. Operand pairs are assembled little-endian: the first byte after the opcode is the low byte.

Top module: `eff_addr_unit`

## Requirements
- R1: After reset, `result`, `mem_access`, `is_imm`, `bad_mode` and `valid` are all 0.
- R2: Mode 0 (byte literal) gives `result = {8'h00, opnd_lo}` with `is_imm=1` and `mem_access=0`. Mode 1 (word literal) gives `result = {opnd_hi, opnd_lo}` with `is_imm=1` and `mem_access=0`.
- R3: Mode 2 (absolute) gives `result = {opnd_hi, opnd_lo}` and `is_imm=0`. `mem_access` is 1 when `abs_jump=0` (data location) and 0 when `abs_jump=1` (jump target).
- R4: Mode 3 (PC-relative) gives `result = pc + 2 + sext(opnd_lo)` modulo 2^16, where `opnd_lo` is a signed two's-complement byte. `mem_access=0`.
- R5: Mode 4 (indexed) gives `result = base + sext(opnd_lo)` modulo 2^16, with `mem_access=1`. The base is `ix` when `idx_sel=0` and `iy` when `idx_sel=1`. A displacement of 80H means -128.
- R6: Mode 5 (pair indirect) gives `result` equal to the pair chosen by `pair_sel`: 0 = `bc`, 1 = `de`, 2 = `hl`, 3 = `sp`. `mem_access=1`.
- R7: Mode 6 (page-zero restart) gives `result = 8 * rst_idx`, which is one of 0000H, 0008H, ... 0038H, with `mem_access=0`.
- R8: Mode 7 is unsupported. It sets `bad_mode=1`, `result=0`, `mem_access=0` and `is_imm=0`. Every other mode leaves `bad_mode=0`.
- R9: `valid` is 1 in exactly the cycle after a clock edge that samples `start=1`. The outputs change on that same edge.
- R10: A clock edge with `start=0` leaves `result`, `mem_access`, `is_imm` and `bad_mode` unchanged, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch a new calculation on this edge |
| mode | input | 3 | Addressing-mode code (0..7) |
| abs_jump | input | 1 | Absolute mode: result is a jump target |
| idx_sel | input | 1 | Indexed base: 0 = ix, 1 = iy |
| pair_sel | input | 2 | Indirect pair: bc, de, hl, sp |
| rst_idx | input | 3 | Restart vector number |
| pc | input | 16 | Program counter of the current instruction |
| bc | input | 16 | Register pair BC |
| de | input | 16 | Register pair DE |
| hl | input | 16 | Register pair HL |
| sp | input | 16 | Stack pointer |
| ix | input | 16 | Index register X |
| iy | input | 16 | Index register Y |
| opnd_lo | input | 8 | First byte after the opcode |
| opnd_hi | input | 8 | Second byte after the opcode |
| result | output | 16 | Address, target or literal |
| mem_access | output | 1 | Result addresses memory |
| is_imm | output | 1 | Result is literal data |
| bad_mode | output | 1 | Unsupported mode code |
| valid | output | 1 | Result updated this cycle |

## Verification
The bench runs all 256 displacements for relative and indexed modes. The base values it uses sit near 0000H and FFFFH, so both wraps are exercised. A design that zero-extended the displacement would miss every negative offset, and one that dropped the +2 would land two bytes short. It runs all eight restart indices, where a wrong shift would produce unaligned or out-of-page vectors. It tries swapped operand bytes, every pair selector and both index selects, which would catch mis-ordered muxes. It also checks the unsupported code and the behaviour when `start` is low: a design that leaked the previous result on mode 7, or that updated on every edge, would show a changed `result` at the ports.

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      mode,
  input  logic            abs_jump,
  input  logic            idx_sel,
  input  logic [1:0]      pair_sel,
  input  logic [2:0]      rst_idx,
  input  logic [2*DW-1:0] pc,
  input  logic [2*DW-1:0] bc,
  input  logic [2*DW-1:0] de,
  input  logic [2*DW-1:0] hl,
  input  logic [2*DW-1:0] sp,
  input  logic [2*DW-1:0] ix,
  input  logic [2*DW-1:0] iy,
  input  logic [DW-1:0]   opnd_lo,
  input  logic [DW-1:0]   opnd_hi,
  output logic [2*DW-1:0] result,
  output logic            mem_access,
  output logic            is_imm,
  output logic            bad_mode,
  output logic            valid
);
  localparam int AW = 2 * DW;
  localparam logic [2:0] M_LIT8 = 3'd0, M_LIT16 = 3'd1, M_ABS = 3'd2, M_REL = 3'd3,
                         M_IDX  = 3'd4, M_PAIR  = 3'd5, M_RST = 3'd6;

  wire [AW-1:0] disp   = {{(AW-DW){opnd_lo[DW-1]}}, opnd_lo};
  wire [AW-1:0] word   = {opnd_hi, opnd_lo};
  wire [AW-1:0] base   = idx_sel ? iy : ix;
  wire [AW-1:0] vector = {{(AW-6){1'b0}}, rst_idx, 3'b000};

  logic [AW-1:0] n_res;
  logic          n_mem, n_imm, n_bad;

  always_comb begin
    n_res = '0;
    n_mem = 1'b0;
    n_imm = 1'b0;
    n_bad = 1'b0;
    unique case (mode)
      M_LIT8:  begin n_res = {{(AW-DW){1'b0}}, opnd_lo}; n_imm = 1'b1; end
      M_LIT16: begin n_res = word; n_imm = 1'b1; end
      M_ABS:   begin n_res = word; n_mem = ~abs_jump; end
      M_REL:   n_res = pc + AW'(2) + disp;
      M_IDX:   begin n_res = base + disp; n_mem = 1'b1; end
      M_PAIR:  begin
        n_mem = 1'b1;
        case (pair_sel)
          2'd0:    n_res = bc;
          2'd1:    n_res = de;
          2'd2:    n_res = hl;
          default: n_res = sp;
        endcase
      end
      M_RST:   n_res = vector;
      default: n_bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      mem_access <= 1'b0;
      is_imm     <= 1'b0;
      bad_mode   <= 1'b0;
      valid      <= 1'b0;
    end else begin
      valid <= start;
      if (start) begin
        result     <= n_res;
        mem_access <= n_mem;
        is_imm     <= n_imm;
        bad_mode   <= n_bad;
      end
    end
  end
endmodule

module eff_addr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [2:0]  mode,
  input logic [15:0] result,
  input logic        mem_access,
  input logic        is_imm,
  input logic        bad_mode,
  input logic        valid
);
  a_r9_valid_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(mem_access) && $stable(is_imm) && $stable(bad_mode)));
  a_r8_bad_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 3'd7) |=> (bad_mode && result == 16'h0 && !mem_access && !is_imm));
  a_r7_vector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 3'd6) |=> (result[15:6] == 10'h0 && result[2:0] == 3'h0 && !mem_access));
  a_r2_literal_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    is_imm |-> !mem_access);
endmodule

bind eff_addr_unit eff_addr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .result(result),
  .mem_access(mem_access), .is_imm(is_imm), .bad_mode(bad_mode), .valid(valid)
);

// File: tb/eff_addr_unit_bench.sv
module eff_addr_unit_bench;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]  mode = '0, rst_idx = '0;
  logic        abs_jump = 1'b0, idx_sel = 1'b0;
  logic [1:0]  pair_sel = '0;
  logic [15:0] pc = '0, bc = 16'h1111, de = 16'h2222, hl = 16'h3333, sp = 16'h4444;
  logic [15:0] ix = '0, iy = '0;
  logic [7:0]  opnd_lo = '0, opnd_hi = '0;
  logic [15:0] result;
  logic        mem_access, is_imm, bad_mode, valid;
  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  eff_addr_unit u_eff_addr_unit (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // flags packed as {valid, bad_mode, is_imm, mem_access}
  task automatic fire(string req, logic [15:0] exp, logic [3:0] flags);
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1;
    check(req, result, exp);
    check(req, {12'h0, valid, bad_mode, is_imm, mem_access}, {12'h0, flags});
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(posedge clk); #1;
    check("R1", {11'h0, result == 16'h0, valid, bad_mode, is_imm, mem_access}, 16'h0010);
    @(negedge clk); rst_n = 1'b1;

    // R2 literals
    mode = 3'd0; opnd_lo = 8'hA5; opnd_hi = 8'h3C;
    fire("R2", 16'h00A5, 4'b1010);
    mode = 3'd1;
    fire("R2", 16'h3CA5, 4'b1010);
    opnd_lo = 8'h01; opnd_hi = 8'hFE;
    fire("R2", 16'hFE01, 4'b1010);

    // R3 absolute
    mode = 3'd2; abs_jump = 1'b0;
    fire("R3", 16'hFE01, 4'b1001);
    abs_jump = 1'b1; opnd_lo = 8'h34; opnd_hi = 8'h12;
    fire("R3", 16'h1234, 4'b1000);

    // R4 relative, all displacements, bases near the wrap points
    mode = 3'd3;
    foreach (pc_set[k]) begin
      pc = pc_set[k];
      for (int d = 0; d < 256; d++) begin
        int off;
        opnd_lo = d[7:0];
        off = (d < 128) ? d : d - 256;
        fire("R4", 16'(int'(pc_set[k]) + 2 + off), 4'b1000);
      end
    end

    // R5 indexed, both index registers
    mode = 3'd4; ix = 16'h0005; iy = 16'hFFF0;
    for (int s = 0; s < 2; s++) begin
      idx_sel = s[0];
      for (int d = 0; d < 256; d++) begin
        int off;
        opnd_lo = d[7:0];
        off = (d < 128) ? d : d - 256;
        fire("R5", 16'(int'(s ? iy : ix) + off), 4'b1001);
      end
    end
    ix = 16'h0080; opnd_lo = 8'h80; idx_sel = 1'b0;
    fire("R5", 16'h0000, 4'b1001);

    // R6 pairs
    mode = 3'd5;
    for (int p = 0; p < 4; p++) begin
      pair_sel = p[1:0];
      fire("R6", 16'h1111 * 16'(p + 1), 4'b1001);
    end

    // R7 restarts
    mode = 3'd6;
    for (int r = 0; r < 8; r++) begin
      rst_idx = r[2:0];
      fire("R7", 16'(r * 8), 4'b1000);
    end

    // R8 unsupported, preceded by a nonzero result
    mode = 3'd1; opnd_lo = 8'hFF; opnd_hi = 8'hFF;
    fire("R2", 16'hFFFF, 4'b1010);
    mode = 3'd7;
    fire("R8", 16'h0000, 4'b1100);

    // R10 / R9: no update without start
    mode = 3'd1; opnd_lo = 8'h77; opnd_hi = 8'h66;
    fire("R2", 16'h6677, 4'b1010);
    held = 16'h6677;
    @(negedge clk); mode = 3'd2; opnd_lo = 8'h11; opnd_hi = 8'h22; abs_jump = 1'b0;
    @(posedge clk); #1;
    check("R10", result, held);
    check("R10", {15'h0, is_imm}, 16'h1);
    check("R9", {15'h0, valid}, 16'h0);
    @(negedge clk); mode = 3'd7;
    @(posedge clk); #1;
    check("R10", {15'h0, bad_mode}, 16'h0);
    check("R10", result, held);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  logic [15:0] pc_set [3] = '{16'h0000, 16'h8000, 16'hFFF0};
endmodule